// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Client Engine

This block is the bus-facing protocol engine of a 512-byte serial EEPROM. It watches the already synchronised and filtered clock and data levels of a two-wire bus, recognises bus Start and Stop events, and checks the device-type code in the first byte of each transaction. It keeps a 9-bit address pointer and either collects incoming bytes for a write or streams stored bytes back to the host. It answers the bus only through a registered pull-down enable for the open-drain data line.

Writes are gathered in a 16-byte page buffer. When the host ends a write with a Stop on a byte boundary, the buffer, a per-byte mask and the page index are handed to the write-cycle controller in a one-cycle commit pulse. While that controller reports busy, the engine gives no acknowledge at all, so a host can poll for completion. For reads, the engine presents the pointer as a read address and takes the returned byte on the same cycle. The memory array and the write-cycle timing live outside this block.

Top module: `tw_mem_client`

## Requirements
- R1: A Start is a falling data line while the clock is high, and a Stop is a rising data line while the clock is high. Data bits are sampled on the clock rising edge. The pull-down enable rises only in the cycle after the clock has been seen low, so the client never starts pulling while the clock is high.
- R2: A first byte whose upper nibble is binary 1010 is acknowledged (bits 3:2 are don't-care). Any other first byte gets no acknowledge, and the engine then ignores the bus until the next Start.
- R3: Bit 1 of the first byte is address bit 8. It selects the lower or upper 256-byte block for both reads and writes.
- R4: In a write (bit 0 of the first byte = 0), the next byte loads address bits 7:0, and every byte is acknowledged by pulling the data line low for the ninth clock.
- R5: Data bytes in a write go to the page buffer slot given by address bits 3:0. These bits then advance and wrap inside the 16-byte page while bits 8:4 stay fixed, so a later byte overwrites an earlier one in the same slot. A Stop whose clock high is the first clock after an acknowledge, in a write holding at least one data byte, gives exactly one commit pulse. The pulse carries a non-zero byte mask, the page index and the buffered bytes.
- R6: While the busy input is high, no byte is acknowledged, including the first byte of a read or a write.
- R7: The pointer moves past every byte written or read. A read with no preceding address (bit 0 of the first byte = 1) returns the byte after the last one accessed.
- R8: A write carrying only an address, followed by a repeated Start and a read first byte, returns the byte at that address and commits nothing.
- R9: A host acknowledge after a read byte makes the next byte follow. The read pointer counts over all 9 bits, so 0x1FF is followed by 0x000.
- R10: After a read byte that the host does not acknowledge, the client releases the data line and drives nothing until the next Start.
- R11: A Start or Stop inside a byte aborts the transaction, and no commit follows.
- R12: After reset the data line is released, no commit is pending and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| busy_i | input | 1 | High while the write-cycle controller is programming |
| sda_pull_o | output | 1 | Registered open-drain pull-down enable for the data line |
| rd_addr_o | output | ADDR_W (9) | Read address, equal to the current pointer |
| rd_data_i | input | 8 | Byte stored at rd_addr_o, valid in the same cycle |
| wr_go_o | output | 1 | One-cycle commit pulse for the page buffer |
| wr_page_o | output | ADDR_W-PAGE_W (5) | Page index of the committed write |
| wr_mask_o | output | 2**PAGE_W (16) | Byte-valid mask of the page buffer |
| wr_data_o | output | 8*2**PAGE_W (128) | Page buffer contents, slot s at bits 8s+7:8s |

## Verification
The first byte is swept over all sixteen upper-nibble codes to separate the one accepted code from every rejected one. A trailing byte after a rejection shows that the engine stays deaf until the next Start. Single-byte writes to the same word address in both blocks tell the block bit apart from the word address. A 20-byte page write starting four slots before the end of a page separates in-page wrap and overwrite from linear addressing, and a read from 0x1FE separates the full 9-bit wrap from the page wrap. Polling right after a commit, writes aborted mid-byte by a Stop or by a Start, and extra clocks after a refused read byte tell correct withholding and discarding apart from acknowledging or committing too early.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam logic [3:0] TW_DEV_CODE = 4'b1010;
    localparam int         TW_BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } tw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tw_evt_t;

    typedef struct packed {
        logic       byte_done;
        logic       ack_end;
        logic       host_ack;
        logic       in_ack;
        logic [3:0] bits;
        logic [7:0] shreg;
    } tw_rx_t;

    function automatic logic dev_hit(input logic [7:0] b);
        return b[7:4] == TW_DEV_CODE;
    endfunction

endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output tw_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
        evt.rise  = scl_i & ~scl_q;
        evt.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/tw_rx_shift.sv
module tw_rx_shift
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tw_evt_t evt,
    input  logic    sda_i,
    output tw_rx_t  rx
);

    logic [3:0] bits_q;
    logic [7:0] sh_q;
    logic       ack_q;
    logic       hack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            sh_q   <= '0;
            ack_q  <= 1'b0;
            hack_q <= 1'b0;
        end else if (evt.start || evt.stop) begin
            bits_q <= '0;
            ack_q  <= 1'b0;
        end else if (evt.rise) begin
            if (ack_q) begin
                hack_q <= ~sda_i;
            end else if (bits_q < 4'(TW_BYTE_W)) begin
                sh_q   <= {sh_q[6:0], sda_i};
                bits_q <= bits_q + 4'd1;
            end
        end else if (evt.fall) begin
            if (ack_q) begin
                ack_q  <= 1'b0;
                bits_q <= '0;
            end else if (bits_q == 4'(TW_BYTE_W)) begin
                ack_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rx.byte_done = evt.fall & ~evt.start & ~evt.stop & ~ack_q & (bits_q == 4'(TW_BYTE_W));
        rx.ack_end   = evt.fall & ~evt.start & ~evt.stop & ack_q;
        rx.host_ack  = hack_q;
        rx.in_ack    = ack_q;
        rx.bits      = bits_q;
        rx.shreg     = sh_q;
    end

endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           we,
    input  logic [PAGE_W-1:0]              slot,
    input  logic [DATA_W-1:0]              din,
    output logic [(1<<PAGE_W)-1:0]         mask_o,
    output logic [(1<<PAGE_W)*DATA_W-1:0]  data_o
);

    localparam int SLOTS = 1 << PAGE_W;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              m_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                m_q <= 1'b0;
                d_q <= '0;
            end else if (we && (slot == PAGE_W'(s))) begin
                m_q <= 1'b1;
                d_q <= din;
            end
        end

        assign mask_o[s]                     = m_q;
        assign data_o[s*DATA_W +: DATA_W]    = d_q;
    end

endmodule

// File: rtl/tw_mem_client.sv
module tw_mem_client
    import tw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                scl_i,
    input  logic                                sda_i,
    input  logic                                busy_i,
    output logic                                sda_pull_o,
    output logic [ADDR_W-1:0]                   rd_addr_o,
    input  logic [7:0]                          rd_data_i,
    output logic                                wr_go_o,
    output logic [ADDR_W-PAGE_W-1:0]            wr_page_o,
    output logic [(1<<PAGE_W)-1:0]              wr_mask_o,
    output logic [(1<<PAGE_W)*TW_BYTE_W-1:0]    wr_data_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BLK_BIT    = ADDR_W - 1;

    tw_evt_t   evt;
    tw_rx_t    rx;
    tw_state_e st_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        txb_q;
    logic              pull_q;
    logic              rd_q;
    logic              go_q;
    logic              buf_we;
    logic              commit_ok;
    logic              tx_bit;
    logic [PAGE_BYTES-1:0] mask;

    tw_line_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    tw_rx_shift u_rx (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .sda_i (sda_i),
        .rx    (rx)
    );

    assign buf_we = rx.byte_done && (st_q == ST_WDATA) && !busy_i;

    tw_page_buf #(
        .PAGE_W (PAGE_W),
        .DATA_W (TW_BYTE_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .clr    (evt.start),
        .we     (buf_we),
        .slot   (ptr_q[PAGE_W-1:0]),
        .din    (rx.shreg),
        .mask_o (mask),
        .data_o (wr_data_o)
    );

    assign commit_ok = (st_q == ST_WDATA) && (|mask) && !rx.in_ack && (rx.bits == 4'd1);
    assign tx_bit    = txb_q[3'd7 - rx.bits[2:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ptr_q  <= '0;
            txb_q  <= '0;
            pull_q <= 1'b0;
            rd_q   <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (evt.start) begin
                st_q   <= ST_CTRL;
                pull_q <= 1'b0;
            end else if (evt.stop) begin
                go_q   <= commit_ok;
                st_q   <= ST_IDLE;
                pull_q <= 1'b0;
            end else if (rx.byte_done) begin
                case (st_q)
                    ST_CTRL: begin
                        if (dev_hit(rx.shreg) && !busy_i) begin
                            pull_q         <= 1'b1;
                            ptr_q[BLK_BIT] <= rx.shreg[1];
                            rd_q           <= rx.shreg[0];
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_ADDR: begin
                        if (!busy_i) begin
                            pull_q      <= 1'b1;
                            ptr_q[7:0]  <= rx.shreg;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_WDATA: begin
                        if (!busy_i) begin
                            pull_q <= 1'b1;
                            ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_RDATA: pull_q <= 1'b0;
                    default:  pull_q <= 1'b0;
                endcase
            end else if (rx.ack_end) begin
                case (st_q)
                    ST_CTRL: begin
                        if (rd_q) begin
                            txb_q  <= rd_data_i;
                            pull_q <= ~rd_data_i[7];
                            ptr_q  <= ptr_q + ADDR_W'(1);
                            st_q   <= ST_RDATA;
                        end else begin
                            pull_q <= 1'b0;
                            st_q   <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        pull_q <= 1'b0;
                        st_q   <= ST_WDATA;
                    end
                    ST_WDATA: pull_q <= 1'b0;
                    ST_RDATA: begin
                        if (rx.host_ack) begin
                            txb_q  <= rd_data_i;
                            pull_q <= ~rd_data_i[7];
                            ptr_q  <= ptr_q + ADDR_W'(1);
                        end else begin
                            pull_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end
                    end
                    default: pull_q <= 1'b0;
                endcase
            end else if (evt.fall && (st_q == ST_RDATA) && !rx.in_ack && (rx.bits != 4'd0)) begin
                pull_q <= ~tx_bit;
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign rd_addr_o  = ptr_q;
    assign wr_go_o    = go_q;
    assign wr_page_o  = ptr_q[ADDR_W-1:PAGE_W];
    assign wr_mask_o  = mask;

endmodule

// File: rtl/tw_mem_client_chk.sv
module tw_mem_client_chk
    import tw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       scl_i,
    input logic                       sda_i,
    input logic                       busy_i,
    input logic                       sda_pull_o,
    input logic                       wr_go_o,
    input logic [(1<<PAGE_W)-1:0]     wr_mask_o,
    input tw_state_e                  st,
    input logic [ADDR_W-PAGE_W-1:0]   pg
);

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(scl_i)); // R1

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_pull_o) && $past(busy_i)) |-> ($past(st) == ST_RDATA)); // R6

    AST_GO_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        wr_go_o |-> ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2))); // R11

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_go_o |=> !wr_go_o); // R5

    AST_GO_MASK: assert property (@(posedge clk) disable iff (rst)
        wr_go_o |-> (|wr_mask_o)); // R5

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WDATA) && ($past(st) == ST_WDATA)) |-> (pg == $past(pg))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_IDLE) && ($past(st) == ST_IDLE)) |-> !sda_pull_o); // R10

endmodule

bind tw_mem_client tw_mem_client_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .busy_i     (busy_i),
    .sda_pull_o (sda_pull_o),
    .wr_go_o    (wr_go_o),
    .wr_mask_o  (wr_mask_o),
    .st         (st_q),
    .pg         (ptr_q[ADDR_W-1:PAGE_W])
);

// File: tb/sim_tw_mem_client.sv
module sim_tw_mem_client;

    localparam int H        = 5;
    localparam int BUSY_CYC = 700;
    localparam int LIMIT    = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic line;
    logic pull;
    logic busy;
    logic [8:0]   rd_addr;
    logic [7:0]   rd_data;
    logic         wr_go;
    logic [4:0]   wr_page;
    logic [15:0]  wr_mask;
    logic [127:0] wr_data;

    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    logic [8:0] exp_ptr;
    int busy_cnt;
    int commits = 0;
    int exp_commits = 0;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int r1_viol = 0;
    logic scl_d = 1'b1;
    logic pull_d = 1'b0;

    always #5 clk = ~clk;

    assign line    = sda_h & ~pull;
    assign rd_data = mem[rd_addr];
    assign busy    = (busy_cnt != 0);

    tw_mem_client u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_h),
        .sda_i      (line),
        .busy_i     (busy),
        .sda_pull_o (pull),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .wr_go_o    (wr_go),
        .wr_page_o  (wr_page),
        .wr_mask_o  (wr_mask),
        .wr_data_o  (wr_data)
    );

    // memory array and write-cycle model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
            busy_cnt <= 0;
        end else if (wr_go) begin
            for (int s = 0; s < 16; s++)
                if (wr_mask[s]) mem[{wr_page, 4'(s)}] <= wr_data[s*8 +: 8];
            busy_cnt <= BUSY_CYC;
            commits  <= commits + 1;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    // R1 monitor: the client must not change the line while the clock stays high
    always @(posedge clk) begin
        if (!rst && scl_h && scl_d && (pull && !pull_d)) r1_viol++;
        scl_d  = scl_h;
        pull_d = pull;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        sda_h = 1'b1; hw(H);
        scl_h = 1'b1; hw(H);
        sda_h = 1'b0; hw(H);
        scl_h = 1'b0; hw(H);
    endtask

    task automatic b_stop();
        sda_h = 1'b0; hw(H);
        scl_h = 1'b1; hw(H);
        sda_h = 1'b1; hw(H);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;    hw(H);
        scl_h = 1'b1; hw(2 * H);
        scl_h = 1'b0; hw(H);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; hw(H);
        scl_h = 1'b1; hw(H);
        b = line;     hw(H);
        scl_h = 1'b0; hw(H);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic ack);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~ack);
    endtask

    function automatic logic [7:0] ctl(input logic blk, input logic rd);
        return {4'b1010, 2'b00, blk, rd};
    endfunction

    function automatic logic [7:0] dv(input logic [7:0] seed, input int k);
        return 8'(seed + 13 * k);
    endfunction

    task automatic wait_idle();
        while (busy) hw(1);
        hw(4);
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] seed);
        logic ack;
        b_start();
        wr_byte(ctl(a[8], 1'b0), ack); chk(ack, "R4 write control ack", ack, 1);
        wr_byte(a[7:0], ack);          chk(ack, "R4 word address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            wr_byte(dv(seed, k), ack);  chk(ack, "R5 data byte ack", ack, 1);
            exp_mem[{a[8:4], 4'(a[3:0] + k)}] = dv(seed, k);
        end
        b_stop();
        if (n > 0) exp_commits++;
        exp_ptr = {a[8:4], 4'(a[3:0] + n)};
    endtask

    task automatic rand_read(input logic [8:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        b_start();
        wr_byte(ctl(a[8], 1'b0), ack); chk(ack, "R8 dummy write control ack", ack, 1);
        wr_byte(a[7:0], ack);          chk(ack, "R8 address ack", ack, 1);
        b_start();
        wr_byte(ctl(a[8], 1'b1), ack); chk(ack, "R8 read control ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(d, k < n - 1);
            chk(d == exp_mem[9'(a + k)], tag, d, exp_mem[9'(a + k)]);
        end
        b_stop();
        exp_ptr = 9'(a + n);
        chk(pull == 1'b0, "R10 line released after last read", pull, 0);
    endtask

    task automatic cur_read(input string tag);
        logic ack;
        logic [7:0] d;
        b_start();
        wr_byte(ctl(exp_ptr[8], 1'b1), ack); chk(ack, "R7 current read control ack", ack, 1);
        rd_byte(d, 1'b0);
        chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
        b_stop();
        exp_ptr = 9'(exp_ptr + 1);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        int ones;
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'(i * 7 + 3);
        exp_ptr = '0;
        hw(6);
        rst = 1'b0;
        hw(2);
        chk(pull == 1'b0, "R12 reset line released", pull, 0);
        chk(wr_go == 1'b0, "R12 reset no commit", wr_go, 0);
        chk(rd_addr == 9'd0, "R12 reset pointer", rd_addr, 0);

        // R2: sweep all device-type codes
        for (int code = 0; code < 16; code++) begin
            b_start();
            wr_byte({4'(code), 3'b000, 1'b0}, ack);
            chk(ack == (code == 10), "R2 device code acceptance", ack, (code == 10));
            if (code == 11) begin
                wr_byte(ctl(1'b0, 1'b0), ack);
                chk(!ack, "R2 ignored until next start", ack, 0);
            end
            b_stop();
        end

        // R3/R4: same word address in both blocks
        do_write(9'h040, 1, 8'h11);
        wait_idle();
        do_write(9'h140, 1, 8'hC4);

        // R6: polling during the write cycle
        b_start();
        wr_byte(ctl(exp_ptr[8], 1'b0), ack);
        chk(!ack && busy, "R6 write control refused while busy", ack, 0);
        b_stop();
        b_start();
        wr_byte(ctl(exp_ptr[8], 1'b1), ack);
        chk(!ack, "R6 read control refused while busy", ack, 0);
        b_stop();
        wait_idle();
        b_start();
        wr_byte(ctl(exp_ptr[8], 1'b0), ack);
        chk(ack, "R6 acknowledge after cycle ends", ack, 1);
        b_stop();

        rand_read(9'h040, 1, "R3 block 0 byte");
        rand_read(9'h140, 1, "R3 block 1 byte");
        chk(exp_mem[9'h040] != exp_mem[9'h140], "R3 blocks distinct", exp_mem[9'h140], 8'hC4);

        // R5: 20-byte page write wrapping inside page 0x030
        do_write(9'h03C, 20, 8'h80);
        wait_idle();
        cur_read("R7 current read after page write");
        cur_read("R7 current read after read");
        rand_read(9'h030, 16, "R5 page contents after wrap");

        // R9: full-range wrap of the read pointer
        rand_read(9'h1FE, 4, "R9 sequential read across top");
        cur_read("R7 current read after wrap");

        // R10: refused read byte, then host keeps clocking
        b_start();
        wr_byte(ctl(exp_ptr[8], 1'b1), ack);
        chk(ack, "R10 read control ack", ack, 1);
        rd_byte(d, 1'b0);
        chk(d == exp_mem[exp_ptr], "R10 data before release", d, exp_mem[exp_ptr]);
        exp_ptr = 9'(exp_ptr + 1);
        ones = 0;
        for (int i = 0; i < 9; i++) begin
            logic b;
            get_bit(b);
            if (b) ones++;
        end
        chk(ones == 9, "R10 no drive after missing host ack", ones, 9);
        b_stop();

        // R11: Stop inside a byte
        b_start();
        wr_byte(ctl(1'b0, 1'b0), ack);
        wr_byte(8'h80, ack);
        wr_byte(8'h55, ack);
        chk(ack, "R11 first data ack before abort", ack, 1);
        for (int i = 0; i < 4; i++) put_bit(i[0]);
        b_stop();
        hw(20);
        chk(commits == exp_commits, "R11 stop mid-byte commits nothing", commits, exp_commits);

        // R11: Start inside a byte
        b_start();
        wr_byte(ctl(1'b0, 1'b0), ack);
        wr_byte(8'h90, ack);
        wr_byte(8'hAA, ack);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        b_start();
        b_stop();
        hw(20);
        chk(commits == exp_commits, "R11 start mid-byte commits nothing", commits, exp_commits);
        rand_read(9'h080, 1, "R11 aborted byte unchanged");
        rand_read(9'h090, 1, "R11 aborted byte unchanged");

        chk(commits == exp_commits, "R5 commit count", commits, exp_commits);
        chk(r1_viol == 0, "R1 pull never starts while clock high", r1_viol, 0);

        summary();
        $finish;
    end

endmodule